// File: doc/BRIEF.md
# Integer Register Bank with Selectable Reset Form

This block holds the 32 general-purpose integer registers of a small load/store processor core. Each register is 32 bits wide. There is one write port and between one and four synchronous read ports; the number of read ports is set by a parameter. The surrounding pipeline never issues a write and a read in the same clock cycle. Because of that rule, the block has no read-during-write behaviour to define. Register 0 is the hard-wired zero register.

A compile-time parameter picks how the storage is built:

- In the memory form (the default), the registers sit in a plain array with no reset, so synthesis can map it onto on-chip RAM. Its contents are undefined until software writes them.
- In the flop form, every register is a discrete flip-flop word, and a hardware reset clears every register to zero.

A constant status output tells software which form was elaborated.

Each read port has its own enable and address. When the enable is high at a rising edge, the selected word appears on that port's data output after the edge. While the enable is low, the output keeps its last value. Writes take effect at the rising edge on which the write enable is high.

Top module: `intreg_bank`

## Requirements
- R1: When a port's read enable is high at a rising edge, that port's data output shows the register selected by its address from just after that edge, which is one clock of latency.
- R2: While a port's read enable is low, that port's data output keeps its previous value, even when its address changes.
- R3: A register changes only at a rising edge where `wr_en` is high; an address and data presented with `wr_en` low leave every register unchanged.
- R4: Register 0 always reads as zero. A write aimed at address 0 is discarded.
- R5: With `CLEAR_ON_RESET` set to 1 (the flop form), an active-low reset forces every register and every read data output to zero. This holds both at start-up and for a reset asserted in mid-operation.
- R6: `cfg_form` is constant. It reads 1 when the flop form with reset was built, and 0 when the memory form was built.
- R7: All read ports work independently in the same cycle. Port p uses address bits [p*5 +: 5] and enable bit p, and returns data on bits [p*32 +: 32].
- R8: Callers never raise `wr_en` together with any read enable. A read issued in the cycle right after a write to the same non-zero register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | 32 | Value to write |
| rd_en | input | NUM_RD | Per-port read strobe |
| rd_addr | input | 5*NUM_RD | Packed per-port register indices |
| rd_data | output | 32*NUM_RD | Packed per-port registered read data |
| cfg_form | output | 1 | 1 when the flop form with reset was built, 0 for the memory form |

## Verification
The case that is hardest to reach from the ports is a reset asserted in mid-operation on the flop form. It must wipe registers that already hold non-zero data. Because of that, the stimulus first fills several registers with distinct patterns, then pulses reset, then reads those same registers back.

A second delicate case is the write followed at once by a read. The bench drops the write strobe and raises a read strobe at the same falling edge, which keeps the two in separate cycles while leaving no gap between them.

Both forms are instantiated side by side. The same stimulus drives them and is compared against one reference model, except that the reset-to-zero checks apply only to the flop form.

// File: rtl/intreg_pkg.sv
package intreg_pkg;

    // Which physical form the storage takes.
    typedef enum logic {
        FORM_MEMORY = 1'b0,
        FORM_FLOPS  = 1'b1
    } store_form_e;

    localparam int unsigned MAX_READ_PORTS = 4;

    // Slice helpers for packed multi-port buses.
    function automatic int unsigned lane_lsb(input int unsigned lane, input int unsigned width);
        return lane * width;
    endfunction

endpackage

// File: rtl/intreg_store.sv
module intreg_store #(
    parameter int DATA_W         = 32,
    parameter int DEPTH          = 32,
    parameter int ADDR_W         = 5,
    parameter int NUM_RD         = 2,
    parameter bit CLEAR_ON_RESET = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_RD-1:0]          rd_en,
    input  logic [NUM_RD*ADDR_W-1:0]   rd_addr,
    output logic [NUM_RD*DATA_W-1:0]   rd_raw
);

    // Writes to index 0 never land in storage.
    logic wr_take;
    assign wr_take = wr_en && (wr_addr != '0);

    generate
        if (CLEAR_ON_RESET) begin : g_flops
            logic [DATA_W-1:0] regs_q [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        regs_q[i] <= '0;
                    end
                end else if (wr_take) begin
                    regs_q[wr_addr] <= wr_data;
                end
            end

            for (genvar p = 0; p < NUM_RD; p++) begin : g_port
                logic [DATA_W-1:0] rd_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        rd_q <= '0;
                    end else if (rd_en[p]) begin
                        rd_q <= regs_q[rd_addr[p*ADDR_W +: ADDR_W]];
                    end
                end
                assign rd_raw[p*DATA_W +: DATA_W] = rd_q;
            end
        end else begin : g_memory
            logic [DATA_W-1:0] mem_q [DEPTH];
            wire unused_rst = rst_n;

            always_ff @(posedge clk) begin
                if (wr_take) begin
                    mem_q[wr_addr] <= wr_data;
                end
            end

            for (genvar p = 0; p < NUM_RD; p++) begin : g_port
                logic [DATA_W-1:0] rd_q;
                always_ff @(posedge clk) begin
                    if (rd_en[p]) begin
                        rd_q <= mem_q[rd_addr[p*ADDR_W +: ADDR_W]];
                    end
                end
                assign rd_raw[p*DATA_W +: DATA_W] = rd_q;
            end
        end
    endgenerate

endmodule

// File: rtl/intreg_zero_mask.sv
module intreg_zero_mask #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] raw_data,
    output logic [DATA_W-1:0] rd_data
);

    // Remembers, alongside the storage read, whether index 0 was requested.
    logic zero_sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_sel_q <= 1'b1;
        end else if (rd_en) begin
            zero_sel_q <= (rd_addr == '0);
        end
    end

    assign rd_data = zero_sel_q ? '0 : raw_data;

endmodule

// File: rtl/intreg_bank.sv
module intreg_bank
    import intreg_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int DEPTH          = 32,
    parameter int NUM_RD         = 2,
    parameter bit CLEAR_ON_RESET = 1'b0,
    localparam int ADDR_W        = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_RD-1:0]          rd_en,
    input  logic [NUM_RD*ADDR_W-1:0]   rd_addr,
    output logic [NUM_RD*DATA_W-1:0]   rd_data,
    output logic                       cfg_form
);

    logic [NUM_RD*DATA_W-1:0] rd_raw;

    store_form_e form_sel;
    assign form_sel = CLEAR_ON_RESET ? FORM_FLOPS : FORM_MEMORY;
    assign cfg_form = form_sel;

    intreg_store #(
        .DATA_W        (DATA_W),
        .DEPTH         (DEPTH),
        .ADDR_W        (ADDR_W),
        .NUM_RD        (NUM_RD),
        .CLEAR_ON_RESET(CLEAR_ON_RESET)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_raw (rd_raw)
    );

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_mask
            intreg_zero_mask #(
                .DATA_W(DATA_W),
                .ADDR_W(ADDR_W)
            ) u_mask (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_en   (rd_en[p]),
                .rd_addr (rd_addr[lane_lsb(p, ADDR_W) +: ADDR_W]),
                .raw_data(rd_raw[lane_lsb(p, DATA_W) +: DATA_W]),
                .rd_data (rd_data[lane_lsb(p, DATA_W) +: DATA_W])
            );
        end
    endgenerate

endmodule

// File: rtl/intreg_bank_checker.sv
module intreg_bank_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int NUM_RD = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [NUM_RD-1:0]        rd_en,
    input logic [NUM_RD*ADDR_W-1:0] rd_addr,
    input logic [NUM_RD*DATA_W-1:0] rd_data
);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|rd_en))); // R8

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_chk
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en[p] |=> $stable(rd_data[p*DATA_W +: DATA_W])); // R2

            AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en[p] && rd_addr[p*ADDR_W +: ADDR_W] == '0)
                |=> rd_data[p*DATA_W +: DATA_W] == '0); // R4

            AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(wr_en) && $past(wr_addr) != '0 && rd_en[p]
                 && rd_addr[p*ADDR_W +: ADDR_W] == $past(wr_addr))
                |=> rd_data[p*DATA_W +: DATA_W] == $past(wr_data, 2)); // R8
        end
    endgenerate

endmodule

bind intreg_bank intreg_bank_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .NUM_RD(NUM_RD)
) u_chk (.*);

// File: tb/intreg_bank_bench.sv
`timescale 1ns/1ps
module intreg_bank_bench;

    localparam int DW = 32;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0] rd_en = '0;
    logic [4*AW-1:0] rd_addr = '0;
    logic [2*DW-1:0] rd_data_m;
    logic [4*DW-1:0] rd_data_f;
    logic form_m, form_f;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [DW-1:0] ref_q [32];

    always #2.5 clk = ~clk;

    // Memory form, default parameters, two ports.
    intreg_bank u_intreg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en[1:0]), .rd_addr(rd_addr[2*AW-1:0]), .rd_data(rd_data_m), .cfg_form(form_m)
    );

    // Flop form with reset, four ports.
    intreg_bank #(.NUM_RD(4), .CLEAR_ON_RESET(1'b1)) u_intreg_bank_ff (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_f), .cfg_form(form_f)
    );

    // Write address, value.
    localparam logic [AW+DW-1:0] VEC [10] = '{
        {5'd1,  32'h1234_5678},
        {5'd2,  32'hFFFF_FFFF},
        {5'd31, 32'hA5A5_5A5A},
        {5'd0,  32'hDEAD_BEEF},
        {5'd7,  32'h0000_0001},
        {5'd16, 32'h8000_0000},
        {5'd2,  32'h0F0F_F0F0},
        {5'd5,  32'hCAFE_0005},
        {5'd30, 32'h0000_0000},
        {5'd9,  32'h7654_3210}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit en);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en && a != '0) ref_q[a] = d;
    endtask

    task automatic do_read(input logic [3:0] en, input logic [4*AW-1:0] addrs);
        @(negedge clk);
        rd_en = en; rd_addr = addrs;
        @(negedge clk);
        rd_en = '0;
    endtask

    function automatic logic [DW-1:0] lane_m(input int p);
        return rd_data_m[p*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] lane_f(input int p);
        return rd_data_f[p*DW +: DW];
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_q[i] = '0;
        repeat (4) @(negedge clk);

        // Start-up reset: form flags and cleared flop form (R5, R6).
        check("R6 memory form flag", {31'd0, form_m}, 32'd0);
        check("R6 flop form flag", {31'd0, form_f}, 32'd1);
        for (int p = 0; p < 4; p++) check("R5 data during reset", lane_f(p), '0);
        rst_n = 1'b1;
        for (int a = 0; a < 32; a++) begin
            do_read(4'b0001, {15'd0, 5'(a)});
            check("R5 register clear after reset", lane_f(0), '0);
        end

        // Vector table walk: write, then read back on both forms (R1, R4).
        for (int i = 0; i < 10; i++) do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], 1'b1);
        for (int i = 0; i < 10; i++) begin
            logic [AW-1:0] a;
            a = VEC[i][AW+DW-1:DW];
            do_read(4'b0001, {15'd0, a});
            check(a == 0 ? "R4 zero register memory" : "R1 readback memory", lane_m(0), ref_q[a]);
            check(a == 0 ? "R4 zero register flops"  : "R1 readback flops",  lane_f(0), ref_q[a]);
        end

        // Write with strobe low leaves register 5 alone (R3).
        do_write(5'd5, 32'hBAD0_BAD0, 1'b0);
        do_read(4'b0010, {10'd0, 5'd5, 5'd0});
        check("R3 suppressed write memory", lane_m(1), 32'hCAFE_0005);
        check("R3 suppressed write flops", lane_f(1), 32'hCAFE_0005);

        // Hold while idle, address moved (R2).
        do_read(4'b0011, {10'd0, 5'd2, 5'd1});
        @(negedge clk);
        rd_addr = {5'd9, 5'd9, 5'd31, 5'd31};
        repeat (2) @(negedge clk);
        check("R2 hold port0 memory", lane_m(0), 32'h1234_5678);
        check("R2 hold port1 memory", lane_m(1), 32'h0F0F_F0F0);
        check("R2 hold port0 flops", lane_f(0), 32'h1234_5678);

        // All ports at once, distinct registers (R7).
        for (int k = 0; k < 4; k++) do_write(5'(10 + k), 32'h1111_0000 * (k + 1) + k, 1'b1);
        do_read(4'b1111, {5'd13, 5'd12, 5'd11, 5'd10});
        for (int k = 0; k < 4; k++) check("R7 parallel port flops", lane_f(k), ref_q[10 + k]);
        check("R7 parallel port0 memory", lane_m(0), ref_q[10]);
        check("R7 parallel port1 memory", lane_m(1), ref_q[11]);
        do_read(4'b0011, {10'd0, 5'd0, 5'd12});
        check("R4 zero on port1 beside live port0", lane_m(1), '0);
        check("R7 port0 unaffected by port1", lane_m(0), ref_q[12]);

        // Write followed at once by a read of the same register (R8).
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h5EED_2020; ref_q[20] = 32'h5EED_2020;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 4'b0001; rd_addr = {15'd0, 5'd20};
        @(negedge clk);
        rd_en = '0;
        check("R8 back-to-back memory", lane_m(0), 32'h5EED_2020);
        check("R8 back-to-back flops", lane_f(0), 32'h5EED_2020);

        // Mid-run reset wipes the flop form (R5).
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(4'b1111, {5'd20, 5'd2, 5'd10, 5'd1});
        for (int k = 0; k < 4; k++) check("R5 mid-run reset clears flops", lane_f(k), '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule